// File: doc/BRIEF.md
# Integer Issue Path with Execution Holding Buffer

This block is the in-order issue path in front of a single integer execution unit. Fetch pushes instructions, each a tag and an opcode, into an eight-entry queue. The oldest entry sits in the decode position and is decoded in one cycle. It then moves either straight into the execution unit or, if the unit is still busy, into a one-entry holding buffer. Most operations occupy the unit for one cycle. A multiply occupies it for five.

When the buffer is full and the unit is busy, the instruction in decode stays where it is. The rest of the queue then fills behind it, so the stall reaches fetch through the full flag. Only the stages behind the busy unit wait; the other stages keep moving. Each finished instruction leaves through a registered write-back stage that carries its tag and opcode. A synchronous flush discards everything not yet in the unit.

Top module: `iu_issue_path`

## Requirements
- R1: After reset, `q_full` and `wb_valid` are both 0.
- R2: The queue holds up to 8 instructions, and the one in decode counts as one of them. `q_full` is 1 in exactly the cycles when 8 are held. A push in a cycle when `q_full` is 1 is dropped and never writes back.
- R3: An instruction pushed at clock edge k into an empty, idle path spends the cycle after edge k in decode, executes in the following cycle, and shows `wb_valid` after edge k+2.
- R4: An opcode of value 5 (multiply) holds the execution unit for 5 cycles. Every other opcode holds it for 1 cycle.
- R5: A decoded instruction that finds the unit busy waits in the one-entry buffer. It enters the unit at the edge where the unit frees.
- R6: While the buffer is occupied and the unit is busy, the instruction in decode does not advance.
- R7: Instructions write back in the order in which their pushes were accepted.
- R8: `wb_valid` pulses for one cycle per instruction. The pulse comes the cycle after the instruction's last execution cycle. `wb_tag` and `wb_op` equal the pushed values.
- R9: `flush` empties the queue, the decode position and the buffer at the next edge, and a push in the same cycle is dropped. An instruction already in the execution unit, or entering it at that edge, still writes back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| flush | input | 1 | Synchronous discard of queue, decode and buffer |
| push_valid | input | 1 | Fetch offers an instruction |
| push_tag | input | TAGW | Tag of the offered instruction |
| push_op | input | OPW | Opcode of the offered instruction |
| q_full | output | 1 | Queue holds 8 instructions |
| wb_valid | output | 1 | Write-back stage holds a finished instruction |
| wb_tag | output | TAGW | Tag of the finished instruction |
| wb_op | output | OPW | Opcode of the finished instruction |

## Verification
Two events can fall on the same edge. The first is the unit freeing, which moves the buffer into the unit while the decode instruction drops into the buffer. The second is a push arriving while the head leaves or while the queue reports full. Back-to-back sequences of multiply, compare and add provoke the first case. Streams of multiplies at different push rates, with occasional flushes, provoke both. The bench computes every instruction's decode-exit, execute-start and write-back edges with a per-instruction timing recurrence. It compares the write-back, the full flag and the order against those edges every cycle.

// File: rtl/iu_issue_path.sv
module iu_issue_path #(
  parameter int DEPTH   = 8,
  parameter int TAGW    = 8,
  parameter int OPW     = 3,
  parameter int MUL_OP  = 5,
  parameter int MUL_CYC = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            flush,
  input  logic            push_valid,
  input  logic [TAGW-1:0] push_tag,
  input  logic [OPW-1:0]  push_op,
  output logic            q_full,
  output logic            wb_valid,
  output logic [TAGW-1:0] wb_tag,
  output logic [OPW-1:0]  wb_op
);
  localparam int CNTW = $clog2(DEPTH + 1);
  localparam int IW   = $clog2(DEPTH);
  localparam int CW   = $clog2(MUL_CYC + 1);
  localparam logic [CW-1:0]  MUL_N = CW'(MUL_CYC);
  localparam logic [OPW-1:0] MULC  = OPW'(MUL_OP);

  logic [TAGW-1:0] q_tag [DEPTH];
  logic [OPW-1:0]  q_op  [DEPTH];
  logic [CNTW-1:0] q_cnt;
  logic            buf_valid, ex_valid;
  logic [TAGW-1:0] buf_tag, ex_tag;
  logic [OPW-1:0]  buf_op, ex_op;
  logic [CW-1:0]   ex_cnt;

  wire head_valid   = q_cnt != '0;
  wire ex_done      = ex_valid && ex_cnt == CW'(1);
  wire ex_free      = !ex_valid || ex_done;
  wire head_leave   = head_valid && (!buf_valid || ex_free);
  wire load_buf     = buf_valid && ex_free;
  wire load_head    = !buf_valid && ex_free && head_valid;
  wire push_ok      = push_valid && !q_full && !flush;
  wire [CNTW-1:0] wr_pos = q_cnt - CNTW'(head_leave);
  wire [IW-1:0]   wr_idx = wr_pos[IW-1:0];

  assign q_full = q_cnt == CNTW'(DEPTH);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)     q_cnt <= '0;
    else if (flush) q_cnt <= '0;
    else            q_cnt <= q_cnt - CNTW'(head_leave) + CNTW'(push_ok);

  always_ff @(posedge clk) begin
    if (head_leave)
      for (int i = 0; i < DEPTH - 1; i++) begin
        q_tag[i] <= q_tag[i+1];
        q_op[i]  <= q_op[i+1];
      end
    if (push_ok) begin
      q_tag[wr_idx] <= push_tag;
      q_op[wr_idx]  <= push_op;
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) buf_valid <= 1'b0;
    else if (flush) buf_valid <= 1'b0;
    else if (head_leave && !load_head) buf_valid <= 1'b1;
    else if (load_buf) buf_valid <= 1'b0;

  always_ff @(posedge clk)
    if (head_leave && !load_head) begin
      buf_tag <= q_tag[0];
      buf_op  <= q_op[0];
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ex_valid <= 1'b0;
      ex_cnt   <= '0;
    end else if (load_buf || load_head) begin
      ex_valid <= 1'b1;
      ex_cnt   <= ((load_buf ? buf_op : q_op[0]) == MULC) ? MUL_N : CW'(1);
    end else if (ex_done) begin
      ex_valid <= 1'b0;
      ex_cnt   <= '0;
    end else if (ex_valid) begin
      ex_cnt   <= ex_cnt - CW'(1);
    end

  always_ff @(posedge clk)
    if (load_buf) begin
      ex_tag <= buf_tag;
      ex_op  <= buf_op;
    end else if (load_head) begin
      ex_tag <= q_tag[0];
      ex_op  <= q_op[0];
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) wb_valid <= 1'b0;
    else        wb_valid <= ex_done;

  always_ff @(posedge clk)
    if (ex_done) begin
      wb_tag <= ex_tag;
      wb_op  <= ex_op;
    end

  a_r2_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    q_cnt <= CNTW'(DEPTH));

  a_r2_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
    q_full && !head_leave && !flush |=> q_full);

  a_r4_mul_countdown: assert property (@(posedge clk) disable iff (!rst_n)
    ex_valid && ex_cnt > CW'(1) && !load_buf && !load_head |=> ex_valid && ex_cnt == $past(ex_cnt) - CW'(1));

  a_r5_buf_needs_busy: assert property (@(posedge clk) disable iff (!rst_n)
    buf_valid |-> ex_valid);

  a_r6_decode_hold: assert property (@(posedge clk) disable iff (!rst_n)
    head_valid && buf_valid && !ex_free && !flush |=> head_valid && $stable(q_tag[0]) && $stable(q_op[0]));

  a_r8_wb_follows_done: assert property (@(posedge clk) disable iff (!rst_n)
    ex_done |=> wb_valid);

  a_r9_flush_clears: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> q_cnt == '0 && !buf_valid);
endmodule

// File: tb/sim_iu_issue_path.sv
module sim_iu_issue_path;
  localparam int PERIOD = 10;
  localparam int NMAX   = 4096;
  localparam logic [2:0] MUL = 3'd5;

  logic clk = 0, rst_n = 0, flush = 0, push_valid = 0;
  logic [7:0] push_tag = 0;
  logic [2:0] push_op = 0;
  logic q_full, wb_valid;
  logic [7:0] wb_tag;
  logic [2:0] wb_op;

  iu_issue_path u0 (.clk(clk), .rst_n(rst_n), .flush(flush), .push_valid(push_valid),
    .push_tag(push_tag), .push_op(push_op), .q_full(q_full), .wb_valid(wb_valid),
    .wb_tag(wb_tag), .wb_op(wb_op));

  always #(PERIOD/2) clk = ~clk;

  int checks = 0, errors = 0, ecnt = 0, n = 0, ord = 0;
  int pd [NMAX]; int ps [NMAX]; int pl [NMAX];
  bit live [NMAX]; bit ret [NMAX];
  logic [7:0] mt [NMAX]; logic [2:0] mo [NMAX];
  int last_d = 0, last_s = 0, last_end = 0;
  int wb_at [256];
  bit full_seen = 0;

  function automatic int lat(logic [2:0] op);
    return (op == MUL) ? 5 : 1;
  endfunction

  function automatic int imax(int a, int b);
    return (a > b) ? a : b;
  endfunction

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d (edge %0d)", what, act, exp, ecnt);
    end
  endtask

  task automatic step(input bit pv, input logic [7:0] tg, input logic [2:0] op, input bit fl);
    int cnt, ej, k, j;
    bit efull;
    cnt = 0; ej = -1;
    for (int i = 0; i < n; i++)
      if (live[i]) begin
        if (pd[i] > ecnt) cnt++;
        if (ps[i] + pl[i] == ecnt) ej = i;
      end
    efull = (cnt == 8);
    chk(q_full == efull, "R2 full flag", int'(q_full), int'(efull));
    if (q_full) full_seen = 1;
    if (ej < 0) chk(wb_valid == 0, "R8 no write-back expected", int'(wb_valid), 0);
    else chk(wb_valid && wb_tag == mt[ej] && wb_op == mo[ej], "R8 write-back tag/op",
             {wb_valid, wb_tag, wb_op}, {1'b1, mt[ej], mo[ej]});
    if (wb_valid) begin
      wb_at[wb_tag] = ecnt;
      while (ord < n && (!live[ord] || ret[ord])) ord++;
      chk(ord < n && wb_tag == mt[ord], "R7 program order", int'(wb_tag), (ord < n) ? int'(mt[ord]) : -1);
      if (ord < n) ret[ord] = 1;
    end
    push_valid = pv; push_tag = tg; push_op = op; flush = fl;
    k = ecnt + 1;
    if (fl) begin
      last_end = 0;
      for (int i = 0; i < n; i++)
        if (live[i]) begin
          if (ps[i] > k) live[i] = 0;
          else last_end = imax(last_end, ps[i] + pl[i]);
        end
      last_d = k; last_s = k;
    end else if (pv && !efull && n < NMAX) begin
      j = n;
      pd[j] = imax(imax(k, last_d) + 1, last_s);
      ps[j] = imax(pd[j], last_end);
      pl[j] = lat(op);
      mt[j] = tg; mo[j] = op; live[j] = 1; ret[j] = 0;
      last_d = pd[j]; last_s = ps[j]; last_end = ps[j] + pl[j];
      n++;
    end
    @(posedge clk);
    ecnt++;
    @(negedge clk);
  endtask

  task automatic idle(input int c);
    for (int i = 0; i < c; i++) step(0, 8'd0, 3'd0, 0);
  endtask

  initial begin
    #(PERIOD * 100000);
    errors++;
    $display("FAIL watchdog R7 progress actual 0 expected 1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int k, rate;
    void'($urandom(32'd4711));
    for (int i = 0; i < 256; i++) wb_at[i] = -1;
    repeat (3) @(negedge clk);
    rst_n = 1;
    chk(q_full == 0 && wb_valid == 0, "R1 reset state", {q_full, wb_valid}, 0);
    idle(2);

    k = ecnt + 1;
    step(1, 8'd200, 3'd0, 0);
    idle(4);
    chk(wb_at[200] == k + 2, "R3 one-cycle decode latency", wb_at[200], k + 2);

    k = ecnt + 1;
    step(1, 8'd201, MUL, 0);
    step(1, 8'd202, 3'd2, 0);
    step(1, 8'd203, 3'd0, 0);
    idle(10);
    chk(wb_at[201] == k + 6, "R4 multiply five cycles", wb_at[201], k + 6);
    chk(wb_at[202] == k + 7, "R5 buffered behind multiply", wb_at[202], k + 7);
    chk(wb_at[203] == k + 8, "R6 decode held while buffer full", wb_at[203], k + 8);

    for (int i = 0; i < 12; i++) step(1, 8'(210 + i), MUL, 0);
    idle(70);
    chk(full_seen == 1, "R2 full reached", int'(full_seen), 1);
    chk(wb_at[221] == -1, "R2 push while full dropped", wb_at[221], -1);
    chk(wb_at[220] != -1, "R2 eighth queued entry retires", wb_at[220], 1);

    for (int i = 0; i < 10; i++) step(1, 8'(230 + i), MUL, 0);
    step(1, 8'd240, 3'd1, 1);
    chk(q_full == 0, "R9 queue empty after flush", int'(q_full), 0);
    idle(20);
    chk(wb_at[231] != -1, "R9 in-unit instruction retires", wb_at[231], 1);
    chk(wb_at[232] == -1, "R9 buffered instruction discarded", wb_at[232], -1);
    chk(wb_at[239] == -1, "R9 queued instruction discarded", wb_at[239], -1);
    chk(wb_at[240] == -1, "R9 push during flush dropped", wb_at[240], -1);

    rate = 50;
    for (int c = 0; c < 3000; c++) begin
      logic [2:0] op;
      if (c % 200 == 0) rate = (($urandom % 3) == 0) ? 20 : ((($urandom % 2) == 0) ? 55 : 95);
      op = (($urandom % 3) == 0) ? MUL : 3'($urandom % 4);
      step(($urandom % 100) < rate, 8'(c), op, ($urandom % 180) == 0);
    end
    idle(80);
    chk(q_full == 0 && wb_valid == 0, "R7 drained at end", {q_full, wb_valid}, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule